// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Controller

This block supervises a microcontroller by watching a bus chip-select line and a low-supply flag and by driving one reset line. Every valid falling edge of chip select counts as a sign of life and restarts a watchdog counter. When the counter runs out, a reset pulse of fixed length is issued. A two-bit select code picks one of three timeout lengths, or it turns the watchdog off.

A separate low-supply flag comes from an external comparator. It forces reset active at once, with no clock needed. After the flag clears, reset is held for a further stretch interval. Every interval is a parameter counted in clock ticks. A chip therefore sets the real-time values, and a bench can shrink them. A parameter also sets the polarity of the reset output.

Chip select and the supply flag are asynchronous. Both pass through flop synchronisers before they reach any counter.

Top module: `sup_ctrl`

## Requirements
- R1: The select code sets the timeout L. Code 2'b00 gives T_LONG ticks, 2'b01 gives T_MID and 2'b10 gives T_SHORT. Code 2'b11 disables the watchdog and no timeout ever fires. The reset first shows L cycles after the clock edge that restarted the count.
- R2: A kick is chip select held low for KICK_MIN consecutive synchronised cycles. The count restarts at the edge that falls KICK_MIN+2 cycles after the input drops. A shorter low pulse does not restart it. If chip select stays low past the timeout, reset still fires.
- R3: A timeout drives reset active for exactly WD_PULSE cycles.
- R4: While reset is active the watchdog count is held at zero. With no kicks, reset goes inactive for exactly L cycles and then fires again.
- R5: An asserted low-supply flag makes reset active in the same cycle, with no clock edge needed. Reset stays active for as long as the flag is asserted.
- R6: Once the low-supply flag is released, reset stays active for exactly PWR_HOLD+1 sampled cycles, counted from the first edge after the release.
- R7: With RST_ACTIVE_HIGH=1 the output is high while reset is active. With RST_ACTIVE_HIGH=0 the output is the inverse.
- R8: Any change of the select code restarts the count at the next edge. Selecting 2'b11 clears any partly run count.
- R9: A kick that lands in the same cycle as a timeout wins. No reset fires, and the count restarts from zero.
- R10: During and right after system reset the output is inactive, unless the supply flag is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low block reset |
| cs_ni | input | 1 | Bus chip select, active low; its falling edge is the kick |
| low_supply_i | input | 1 | Low-supply flag from an external comparator, active high |
| wd_sel_i | input | 2 | Watchdog select code (long, mid, short, off) |
| sup_rst_o | output | 1 | Reset output, polarity set by RST_ACTIVE_HIGH |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both.

The first pair is a kick and a timeout. The bench places the chip-select drop so that the kick arrives in exactly the cycle the count reaches its limit. The reset must then first appear a full timeout later. A second run drops chip select one cycle later, and this time the timeout must win.

The second pair is a watchdog pulse and a supply fault. The bench raises the supply flag in the middle of a watchdog pulse. Reset must stay active without a gap and must release exactly PWR_HOLD+1 cycles after the flag clears.

// File: rtl/sup_pkg.sv
// Shared types and helpers for the supervisory reset controller.
package sup_pkg;

    // Watchdog select codes; the numeric values are the register field encoding.
    typedef enum logic [1:0] {
        WD_SEL_LONG  = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_SHORT = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;

    // Largest of three tick counts, used to size the watchdog counter.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2; RST_VAL is the level held while the block is in reset.
module sup_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sup_kick_filt.sv
// Turns a synchronised active-low chip select into a one-cycle kick.
// The kick fires once, on the KICK_MIN-th consecutive low cycle, so a
// shorter pulse is ignored. Assumes KICK_MIN >= 1.
module sup_kick_filt #(
    parameter int unsigned KICK_MIN = 80
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_sync_i,
    output logic kick_o
);
    localparam int unsigned RW = $clog2(KICK_MIN + 1);
    localparam logic [RW-1:0] RUN_SAT  = RW'(KICK_MIN);
    localparam logic [RW-1:0] RUN_FIRE = RW'(KICK_MIN - 1);

    logic [RW-1:0] run_q;

    // Count consecutive low cycles, saturating once the minimum is reached.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                run_q <= '0;
        else if (cs_sync_i)         run_q <= '0;
        else if (run_q != RUN_SAT)  run_q <= run_q + 1'b1;
    end

    assign kick_o = !cs_sync_i && (run_q == RUN_FIRE);
endmodule

// File: rtl/sup_wdog.sv
// Watchdog counter. It counts up while enabled and restarts on a kick, on a
// select change, while disabled, or while reset is held. It raises fire_o
// for one cycle when the selected limit is reached.
// Assumes every enabled limit is at least 2 ticks.
module sup_wdog
    import sup_pkg::*;
#(
    parameter int unsigned T_LONG  = 280_000_000,
    parameter int unsigned T_MID   = 120_000_000,
    parameter int unsigned T_SHORT = 40_000_000,
    parameter int unsigned CNT_W   = 29
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       sel_i,
    input  logic             kick_i,
    input  logic             hold_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] cnt_o
);
    wd_sel_e          sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             enabled;
    logic             restart;

    // Map the select code to its limit in ticks.
    always_comb begin
        case (sel_i)
            WD_SEL_LONG:  lim = CNT_W'(T_LONG);
            WD_SEL_MID:   lim = CNT_W'(T_MID);
            WD_SEL_SHORT: lim = CNT_W'(T_SHORT);
            default:      lim = '0;
        endcase
    end

    assign enabled = (sel_i != WD_SEL_OFF);
    assign restart = !enabled || kick_i || hold_i || (sel_i != sel_q);
    assign fire_o  = !restart && (cnt_q == lim - 1'b1);

    // Remember the last select code so that a change can be detected.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sel_q <= WD_SEL_OFF;
        else         sel_q <= wd_sel_e'(sel_i);
    end

    // Advance the count, or clear it on a restart or a timeout.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (restart || fire_o) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sup_rstgen.sv
// Reset pulse generator. It merges a fixed-length watchdog pulse with a
// supply-fault hold and a post-recovery stretch. The raw supply flag forces
// the output with no clock. Assumes WD_PULSE >= 1 and PWR_HOLD >= 1.
module sup_rstgen #(
    parameter int unsigned WD_PULSE = 40_000_000,
    parameter int unsigned PWR_HOLD = 40_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic lowv_raw_i,
    input  logic lowv_sync_i,
    output logic active_o
);
    localparam int unsigned WW = $clog2(WD_PULSE + 1);
    localparam int unsigned PW = $clog2(PWR_HOLD + 1);

    logic [WW-1:0] wd_left_q;
    logic [PW-1:0] pwr_left_q;

    // Load the watchdog pulse length on a timeout, then count it down.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                wd_left_q <= '0;
        else if (fire_i)            wd_left_q <= WW'(WD_PULSE);
        else if (wd_left_q != '0)   wd_left_q <= wd_left_q - 1'b1;
    end

    // Reload the stretch while the supply is low, then count it down.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                pwr_left_q <= '0;
        else if (lowv_sync_i)       pwr_left_q <= PW'(PWR_HOLD);
        else if (pwr_left_q != '0)  pwr_left_q <= pwr_left_q - 1'b1;
    end

    assign active_o = lowv_raw_i || lowv_sync_i || (pwr_left_q != '0) || (wd_left_q != '0);
endmodule

// File: rtl/sup_ctrl.sv
// Supervisory watchdog and reset controller, top level.
// It synchronises chip select and the supply flag, filters chip select into
// kicks, runs the watchdog and merges every reset source onto one output
// of selectable polarity. All intervals are in system clock ticks.
module sup_ctrl
    import sup_pkg::*;
#(
    parameter int unsigned T_LONG          = 280_000_000,
    parameter int unsigned T_MID           = 120_000_000,
    parameter int unsigned T_SHORT         = 40_000_000,
    parameter int unsigned WD_PULSE        = 40_000_000,
    parameter int unsigned PWR_HOLD        = 40_000_000,
    parameter int unsigned KICK_MIN        = 80,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter bit          RST_ACTIVE_HIGH = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cs_ni,
    input  logic       low_supply_i,
    input  logic [1:0] wd_sel_i,
    output logic       sup_rst_o
);
    localparam int unsigned T_MAX = max3(T_LONG, T_MID, T_SHORT);
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);

    logic             cs_sync;
    logic             lowv_sync;
    logic             kick;
    logic             wd_fire;
    logic             rst_active;
    logic [CNT_W-1:0] wd_cnt;

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_sync)
    );

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lv_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(low_supply_i), .q_o(lowv_sync)
    );

    sup_kick_filt #(.KICK_MIN(KICK_MIN)) u_kick (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_sync_i(cs_sync), .kick_o(kick)
    );

    sup_wdog #(
        .T_LONG(T_LONG), .T_MID(T_MID), .T_SHORT(T_SHORT), .CNT_W(CNT_W)
    ) u_wdog (
        .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(wd_sel_i), .kick_i(kick),
        .hold_i(rst_active), .fire_o(wd_fire), .cnt_o(wd_cnt)
    );

    sup_rstgen #(.WD_PULSE(WD_PULSE), .PWR_HOLD(PWR_HOLD)) u_rgen (
        .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(wd_fire),
        .lowv_raw_i(low_supply_i), .lowv_sync_i(lowv_sync), .active_o(rst_active)
    );

    // Drive the output in the polarity the build selects.
    generate
        if (RST_ACTIVE_HIGH) begin : g_pol_high
            assign sup_rst_o = rst_active;
        end else begin : g_pol_low
            assign sup_rst_o = !rst_active;
        end
    endgenerate
endmodule

// File: rtl/sup_ctrl_chk.sv
// Temporal checks on the supervisory controller, attached by bind.
module sup_ctrl_chk #(
    parameter int unsigned CW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          kick,
    input logic [CW-1:0] wd_cnt,
    input logic          wd_fire,
    input logic          rst_active,
    input logic          low_supply_i,
    input logic [1:0]    wd_sel_i
);
    AST_KICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick |=> (wd_cnt == '0)); // R2
    AST_FIRE_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_fire |=> rst_active); // R3
    AST_FIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_fire |=> !wd_fire); // R3
    AST_HOLD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_active |=> (wd_cnt == '0)); // R4
    AST_LOWV_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_supply_i |-> rst_active); // R5
    AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wd_sel_i == 2'b11) |=> (wd_cnt == '0)); // R8
endmodule

bind sup_ctrl sup_ctrl_chk #(.CW(CNT_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .kick(kick), .wd_cnt(wd_cnt),
    .wd_fire(wd_fire), .rst_active(rst_active), .low_supply_i(low_supply_i),
    .wd_sel_i(wd_sel_i)
);

// File: tb/tb_sup_ctrl.sv
`timescale 1ns/1ps
module tb_sup_ctrl;
    localparam int TL = 60, TM = 40, TS = 20, WP = 12, PH = 16, KM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic lowv = 1'b0;
    logic [1:0] sel = 2'b11;
    logic rst_h, rst_l;
    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sup_ctrl #(.T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .WD_PULSE(WP), .PWR_HOLD(PH),
               .KICK_MIN(KM), .RST_ACTIVE_HIGH(1'b1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .low_supply_i(lowv),
        .wd_sel_i(sel), .sup_rst_o(rst_h));

    sup_ctrl #(.T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .WD_PULSE(WP), .PWR_HOLD(PH),
               .KICK_MIN(KM), .RST_ACTIVE_HIGH(1'b0)) dut_n (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .low_supply_i(lowv),
        .wd_sel_i(sel), .sup_rst_o(rst_l));

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'b00:   return TL;
            2'b01:   return TM;
            2'b10:   return TS;
            default: return 0;
        endcase
    endfunction

    task automatic chk_eq(input string req, input int a, input int e);
        nchk++;
        if (a != e) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, a, e);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sel = 2'b11; cs_n = 1'b1; lowv = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (!rst_h) break;
            step();
        end
        step(); step();
    endtask

    // Run n samples with chip select changes at given steps; return first active sample.
    task automatic first_active(input int n, input int lo_at, input int hi_at, output int first);
        first = 0;
        for (int i = 1; i <= n; i++) begin
            step();
            if (i == lo_at) cs_n = 1'b0;
            if (i == hi_at) cs_n = 1'b1;
            if (rst_h && first == 0) first = i;
        end
    endtask

    task automatic count_active(output int n);
        n = 0;
        for (int i = 0; i < 500; i++) begin
            step();
            if (rst_h) n++; else break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int f, n, q, lim;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        repeat (5) step();
        chk_eq("R10 active during reset", rst_h, 0);
        chk_eq("R7 low polarity in reset", rst_l, 1);
        rst_n = 1'b1;
        q = 0;
        for (int i = 0; i < 10; i++) begin step(); q += rst_h; end
        chk_eq("R10 quiet after reset", q, 0);

        // Timeout length, pulse length and rearm period for each code.
        for (int c = 0; c < 3; c++) begin
            idle();
            sel = 2'(c);
            lim = lim_of(sel);
            q = 0;
            for (int i = 0; i < lim; i++) begin step(); q += rst_h; end
            chk_eq("R1 quiet before limit", q, 0);
            step();
            chk_eq("R1 reset at limit", rst_h, 1);
            chk_eq("R7 inverse output", rst_l, 0);
            n = 1;
            for (int i = 0; i < 500; i++) begin step(); if (rst_h) n++; else break; end
            chk_eq("R3 pulse length", n, WP);
            n = 1;
            for (int i = 0; i < 500; i++) begin step(); if (!rst_h) n++; else break; end
            chk_eq("R4 rearm gap", n, lim);
        end

        // Disabled code never fires.
        idle();
        q = 0;
        for (int i = 0; i < 3 * TL; i++) begin step(); q += rst_h; end
        chk_eq("R1 off quiet", q, 0);

        // Kick with chip select held low, then a too-short pulse.
        idle(); sel = 2'b10;
        first_active(40, 2, 0, f);
        chk_eq("R2 held low fires after kick", f, 2 + KM + 2 + TS);
        idle(); sel = 2'b10;
        first_active(40, 5, 5 + KM - 1, f);
        chk_eq("R2 short pulse ignored", f, TS + 1);

        // Select change restarts; entering off clears the count.
        idle(); sel = 2'b00;
        f = 0;
        for (int i = 1; i <= 90; i++) begin
            step();
            if (i == 30) sel = 2'b01;
            if (rst_h && f == 0) f = i;
        end
        chk_eq("R8 change restarts", f, 31 + TM);
        idle(); sel = 2'b10;
        f = 0;
        for (int i = 1; i <= 50; i++) begin
            step();
            if (i == 15) sel = 2'b11;
            if (i == 17) sel = 2'b10;
            if (rst_h && f == 0) f = i;
        end
        chk_eq("R8 off clears", f, 18 + TS);

        // Kick and timeout in the same cycle, then one cycle late.
        idle(); sel = 2'b10;
        first_active(2 * TS + 5, TS - KM - 1, 0, f);
        chk_eq("R9 kick wins", f, 2 * TS + 1);
        idle(); sel = 2'b10;
        first_active(2 * TS + 5, TS - KM, 0, f);
        chk_eq("R9 late kick loses", f, TS + 1);

        // Supply fault: immediate, held, stretched.
        idle();
        lowv = 1'b1;
        #1;
        chk_eq("R5 immediate", rst_h, 1);
        chk_eq("R7 immediate inverse", rst_l, 0);
        q = 0;
        for (int i = 0; i < 10; i++) begin step(); q += rst_h; end
        chk_eq("R5 held", q, 10);
        lowv = 1'b0;
        count_active(n);
        chk_eq("R6 stretch", n, PH + 1);

        // Supply fault on top of a watchdog pulse.
        idle(); sel = 2'b10;
        for (int i = 0; i < 60; i++) begin if (rst_h) break; step(); end
        repeat (3) step();
        lowv = 1'b1;
        repeat (3) step();
        lowv = 1'b0; sel = 2'b11;
        count_active(n);
        chk_eq("R6 stretch over watchdog pulse", n, PH + 1);

        // Random kicking inside the window never resets.
        for (int it = 0; it < 6; it++) begin
            idle();
            sel = 2'($urandom_range(0, 2));
            lim = lim_of(sel);
            q = 0;
            for (int k = 0; k < 12; k++) begin
                cs_n = 1'b0;
                repeat ($urandom_range(KM, KM + 3)) begin step(); q += rst_h; end
                cs_n = 1'b1;
                repeat ($urandom_range(2, lim - KM - 8)) begin step(); q += rst_h; end
            end
            chk_eq("R2 random kicks hold off reset", q, 0);
        end

        // Random supply fault lengths.
        for (int it = 0; it < 6; it++) begin
            idle();
            lowv = 1'b1;
            repeat ($urandom_range(1, 8)) step();
            lowv = 1'b0;
            count_active(n);
            chk_eq("R6 random stretch", n, PH + 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule